// File: doc/BRIEF.md
# Multi-Channel Packet DMA Engine

This block moves endpoint data between system memory and the endpoint FIFOs of a USB device controller. It has a parameterised number of channels, eight by default. Software sets up each channel through a small register window. It writes a word-aligned start address and a byte count. It then writes the channel's control word with the start bit set, together with the direction, the mode, the endpoint, the burst size and the interrupt enable.

A channel waits for the FIFO request line of its endpoint and then moves one packet as a series of memory bursts. After each burst it advances its address and lowers its count. In single-packet mode the channel stops after that one packet. In multi-packet mode it waits for the FIFO request again before each further packet, until the count reaches zero. When channels compete for the bus, a fixed-priority arbiter serves them one burst at a time. A bus error response stops the channel and latches a flag. Completions collect in a status byte that is cleared when it is read.

The memory side is a simplified master. It holds a request with an address, a beat count, a direction, the channel and the endpoint until the slave returns a done or error pulse. The FIFO data path itself is outside this block.

Top module: `pkt_dma_engine`

## Requirements
- R1: Channel n occupies byte offsets 0x200+16n+{4,8,C}, holding the control, address and count registers. In the control word, bit 0 = start/active, bit 1 = transmit (memory read, `mem_write`=0), bit 2 = multi-packet mode, bit 3 = interrupt enable, bits 7:4 = endpoint, bit 8 = bus error, bits 10:9 = burst code. The other fields read back as written. Writing the control word clears bit 8.
- R2: The address register always reads back with bits 1:0 forced to zero.
- R3: Each burst is issued at the channel's current address. After each burst the address rises and the count falls by the bytes moved. At the end, the address minus the aligned start address equals the bytes moved.
- R4: A burst carries min(burst size, words left in the packet) beats, where burst code 0/1/2/3 gives 1/4/8/16 beats of 4 bytes. The request fields stay stable until the response.
- R5: In single-packet mode a channel moves min(count, 64) bytes once its FIFO request is seen, then stops.
- R6: In multi-packet mode a channel issues nothing until `fifo_req[endpoint]` is high, and waits for it again before each further 64-byte packet, until the count reaches zero.
- R7: An error response stops the channel. It sets control bit 8, clears bit 0, and leaves the address and count unchanged.
- R8: A finished or failed channel sets its bit of the status byte at offset 0x200 only when its interrupt enable is set. `irq` is high while any status bit is set.
- R9: Reading offset 0x200 clears the status bits. A completion in the same cycle as the read is kept for the next read.
- R10: Writing a control word with bit 0 clear aborts the channel. It issues no further bursts and raises no interrupt.
- R11: When several channels want the bus, the lowest-numbered channel is granted, one burst per grant.
- R12: Starting a channel with a count of zero finishes it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at offset 0x200) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Burst request, held until done or error |
| mem_write | output | 1 | 1 = burst writes memory (receive), 0 = reads memory |
| mem_addr | output | 32 | Burst start address |
| mem_beats | output | 5 | Beats in the burst (1 to 16) |
| mem_ch | output | 3 | Channel owning the burst |
| mem_ep | output | 4 | Endpoint of the owning channel |
| mem_done | input | 1 | Burst completed |
| mem_err | input | 1 | Burst ended with a bus error |
| fifo_req | input | 16 | Per-endpoint request for a packet |
| irq | output | 1 | Any status bit set |

## Verification
Directed cases cover the corners one at a time. A single-beat burst finishing in the same cycle as a status read tells a kept completion from a lost one. A zero count separates the immediate finish from a stalled channel. Holding the FIFO request low and then pulsing it separates per-packet waiting from free running, and aborting a waiting channel shows that nothing leaks out. Two channels released together show whether the lower one takes all of its bursts first. Random rounds then mix channels, counts that are not multiples of four, both modes, all burst codes and a toggling FIFO request. Every burst is checked against a model of address and size, and the final address and count are checked against the bytes each mode should move.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;
  localparam int CB_EN    = 0;
  localparam int CB_TX    = 1;
  localparam int CB_MULTI = 2;
  localparam int CB_IE    = 3;
  localparam int CB_EP    = 4;
  localparam int CB_ERR   = 8;
  localparam int CB_BURST = 9;

  typedef enum logic [1:0] {CH_IDLE, CH_WAIT, CH_RUN} ch_state_e;

  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      2'd3:    return 5'd16;
      default: return 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import pkt_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PKT_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic [AW-1:0] wdata,
  input  logic          pkt_ok,
  input  logic          bus_done,
  input  logic          bus_err,
  output logic [15:0]   ctrl_rd,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] cnt_q,
  output logic [3:0]    ep,
  output logic          want,
  output logic [4:0]    beats,
  output logic          tx,
  output logic          en,
  output logic          fin
);
  localparam int PW = $clog2(PKT_BYTES + 1);
  localparam int BW = (PW > 7) ? PW : 7;

  ch_state_e     state_q, state_d;
  logic [6:0]    lo_q, lo_d;      // control bits 7:1
  logic [1:0]    burst_q, burst_d;
  logic          err_q, err_d;
  logic [PW-1:0] pkt_q, pkt_d;
  logic [AW-1:0] addr_d, cnt_d;
  logic [BW-1:0] cap_b, pkt_b, bytes, rnd;
  logic [PW-1:0] pkt_first;

  assign cap_b     = BW'({burst_beats(burst_q), 2'b00});
  assign pkt_b     = BW'(pkt_q);
  assign bytes     = (cap_b < pkt_b) ? cap_b : pkt_b;
  assign rnd       = bytes + BW'(3);
  assign beats     = rnd[6:2];
  assign pkt_first = (cnt_q < AW'(PKT_BYTES)) ? cnt_q[PW-1:0] : PW'(PKT_BYTES);

  assign en      = (state_q != CH_IDLE);
  assign want    = (state_q == CH_RUN);
  assign tx      = lo_q[CB_TX-1];
  assign ep      = lo_q[6:3];
  assign ctrl_rd = {5'b0, burst_q, err_q, lo_q, en};

  always_comb begin
    state_d = state_q;
    lo_d    = lo_q;
    burst_d = burst_q;
    err_d   = err_q;
    pkt_d   = pkt_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    fin     = 1'b0;
    if (wr_addr) addr_d = {wdata[AW-1:2], 2'b00};
    if (wr_cnt)  cnt_d  = wdata;
    case (state_q)
      CH_WAIT: if (pkt_ok) begin
        state_d = CH_RUN;
        pkt_d   = pkt_first;
      end
      CH_RUN: begin
        if (bus_err) begin
          err_d   = 1'b1;
          state_d = CH_IDLE;
          fin     = lo_q[CB_IE-1];
        end else if (bus_done) begin
          addr_d = addr_q + AW'(bytes);
          cnt_d  = cnt_q - AW'(bytes);
          pkt_d  = pkt_q - bytes[PW-1:0];
          if (cnt_q == AW'(bytes) || (pkt_b == bytes && !lo_q[CB_MULTI-1])) begin
            state_d = CH_IDLE;
            fin     = lo_q[CB_IE-1];
          end else if (pkt_b == bytes) begin
            state_d = CH_WAIT;
          end
        end
      end
      default: ;
    endcase
    if (wr_ctrl) begin
      lo_d    = wdata[7:1];
      burst_d = wdata[CB_BURST+1:CB_BURST];
      err_d   = 1'b0;
      if (!wdata[CB_EN]) begin
        state_d = CH_IDLE;
      end else if (cnt_q == '0) begin
        state_d = CH_IDLE;
        fin     = wdata[CB_IE];
      end else begin
        state_d = CH_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      lo_q    <= '0;
      burst_q <= '0;
      err_q   <= 1'b0;
      pkt_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      lo_q    <= lo_d;
      burst_q <= burst_d;
      err_q   <= err_d;
      pkt_q   <= pkt_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] want,
  input  logic           resp,
  output logic           busy_q,
  output logic [CHW-1:0] cur_q
);
  logic           busy_d, found;
  logic [CHW-1:0] cur_d, pick;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (want[i]) begin
        pick  = CHW'(i);
        found = 1'b1;
      end
    end
    busy_d = busy_q ? !resp : found;
    cur_d  = (!busy_q && found) ? pick : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/dma_irq_stat.sv
module dma_irq_stat #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_clr,
  input  logic [NCH-1:0] set_vec,
  output logic [NCH-1:0] stat_q,
  output logic           irq
);
  logic [NCH-1:0] stat_d;

  assign stat_d = (rd_clr ? '0 : stat_q) | set_vec;
  assign irq    = |stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/pkt_dma_engine.sv
module pkt_dma_engine
  import pkt_dma_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int AW        = 32,
  parameter int NEP       = 16,
  parameter int PKT_BYTES = 64,
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [11:0]    reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  output logic           mem_req,
  output logic           mem_write,
  output logic [AW-1:0]  mem_addr,
  output logic [4:0]     mem_beats,
  output logic [CHW-1:0] mem_ch,
  output logic [3:0]     mem_ep,
  input  logic           mem_done,
  input  logic           mem_err,
  input  logic [NEP-1:0] fifo_req,
  output logic           irq
);
  logic [7:0]     slot;
  logic           in_range, stat_hit;
  logic [CHW-1:0] sel_ch;
  logic [3:0]     off;
  logic [NCH-1:0] en_vec, want_vec, fin_vec, stat_q;
  logic [15:0]    ctrl_arr [NCH];
  logic [AW-1:0]  addr_arr [NCH];
  logic [AW-1:0]  cnt_arr  [NCH];
  logic [3:0]     ep_arr   [NCH];
  logic [4:0]     beats_arr[NCH];
  logic [NCH-1:0] tx_vec;
  logic           busy_q;
  logic [CHW-1:0] cur_q;

  assign slot     = reg_addr[11:4] - 8'h20;
  assign in_range = (reg_addr[11:4] >= 8'h20) && (int'(slot) < NCH);
  assign sel_ch   = slot[CHW-1:0];
  assign off      = reg_addr[3:0];
  assign stat_hit = (reg_addr == 12'h200);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = reg_wr && in_range && (sel_ch == CHW'(g));
    dma_chan #(.AW(AW), .PKT_BYTES(PKT_BYTES)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (hit && off == 4'h4),
      .wr_addr  (hit && off == 4'h8),
      .wr_cnt   (hit && off == 4'hC),
      .wdata    (reg_wdata),
      .pkt_ok   (fifo_req[ep_arr[g]]),
      .bus_done (mem_done && busy_q && cur_q == CHW'(g)),
      .bus_err  (mem_err && busy_q && cur_q == CHW'(g)),
      .ctrl_rd  (ctrl_arr[g]),
      .addr_q   (addr_arr[g]),
      .cnt_q    (cnt_arr[g]),
      .ep       (ep_arr[g]),
      .want     (want_vec[g]),
      .beats    (beats_arr[g]),
      .tx       (tx_vec[g]),
      .en       (en_vec[g]),
      .fin      (fin_vec[g])
    );
  end

  dma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .want   (want_vec),
    .resp   (mem_done || mem_err),
    .busy_q (busy_q),
    .cur_q  (cur_q)
  );

  dma_irq_stat #(.NCH(NCH)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_clr  (reg_rd && stat_hit),
    .set_vec (fin_vec),
    .stat_q  (stat_q),
    .irq     (irq)
  );

  assign mem_req   = busy_q;
  assign mem_ch    = cur_q;
  assign mem_addr  = addr_arr[cur_q];
  assign mem_beats = beats_arr[cur_q];
  assign mem_ep    = ep_arr[cur_q];
  assign mem_write = !tx_vec[cur_q];

  always_comb begin
    reg_rdata = '0;
    if (stat_hit)                   reg_rdata = AW'(stat_q);
    else if (in_range && off == 4'h4) reg_rdata = AW'(ctrl_arr[sel_ch]);
    else if (in_range && off == 4'h8) reg_rdata = addr_arr[sel_ch];
    else if (in_range && off == 4'hC) reg_rdata = cnt_arr[sel_ch];
  end
endmodule

// File: rtl/pkt_dma_chk.sv
module pkt_dma_chk #(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_done,
  input logic           mem_err,
  input logic [AW-1:0]  mem_addr,
  input logic [4:0]     mem_beats,
  input logic [CHW-1:0] mem_ch,
  input logic           reg_rd,
  input logic [11:0]    reg_addr,
  input logic [NCH-1:0] stat,
  input logic [NCH-1:0] en_vec,
  input logic [NCH-1:0] want_vec
);
  logic [NCH-1:0] low_mask;
  assign low_mask = (NCH'(1) << mem_ch) - NCH'(1);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done && !mem_err |=> mem_req && $stable(mem_addr) && $stable(mem_ch) && $stable(mem_beats)); // R4
  AST_BEATS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_beats != 5'd0) && (mem_beats <= 5'd16)); // R4
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (($past(want_vec) & low_mask) == '0)); // R11
  AST_STAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == 12'h200) |=> ((stat & $past(stat)) == $past(stat))); // R9
  AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_err |=> !en_vec[$past(mem_ch)]); // R7
endmodule

bind pkt_dma_engine pkt_dma_chk #(.NCH(NCH), .AW(AW), .CHW(CHW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_done  (mem_done),
  .mem_err   (mem_err),
  .mem_addr  (mem_addr),
  .mem_beats (mem_beats),
  .mem_ch    (mem_ch),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .stat      (stat_q),
  .en_vec    (en_vec),
  .want_vec  (want_vec)
);

// File: tb/tb_pkt_dma_engine.sv
module tb_pkt_dma_engine;
  localparam int PKT = 64;

  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_write, mem_done, mem_err, irq;
  logic [31:0] mem_addr;
  logic [4:0]  mem_beats;
  logic [2:0]  mem_ch;
  logic [3:0]  mem_ep;
  logic [15:0] fifo_req;

  pkt_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_beats(mem_beats), .mem_ch(mem_ch), .mem_ep(mem_ep),
    .mem_done(mem_done), .mem_err(mem_err), .fifo_req(fifo_req), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nchk = 0, nbad = 0;
  logic [31:0] m_addr[8], m_cnt[8], m_pkt[8];
  logic        m_multi[8], m_tx[8];
  logic [1:0]  m_burst[8];
  logic        auto_resp = 1'b1, err_arm = 1'b0;
  int          err_ch = 0, bursts = 0, glog_n = 0;
  int          glog[16];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cap_bytes(input logic [1:0] b);
    return (b == 2'd0) ? 32'd4 : (32'd16 << (b - 2'd1));
  endfunction

  function automatic logic [31:0] moved(input logic [31:0] cnt, input logic multi);
    return multi ? cnt : ((cnt < PKT) ? cnt : PKT);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [11:0] ra(input int ch, input int o);
    return 12'(12'h200 + 16 * ch + o);
  endfunction

  task automatic start_ch(input int ch, input logic [31:0] a, input logic [31:0] c,
                          input logic multi, input logic [1:0] b, input logic ie,
                          input logic t, input logic [3:0] e);
    m_addr[ch] = {a[31:2], 2'b00}; m_cnt[ch] = c; m_pkt[ch] = 0;
    m_multi[ch] = multi; m_burst[ch] = b; m_tx[ch] = t;
    wr(ra(ch, 8), a);
    wr(ra(ch, 12), c);
    wr(ra(ch, 4), {21'b0, b, 1'b0, e, ie, multi, t, 1'b1});
  endtask

  // memory responder with per-burst checks against the model
  initial begin
    mem_done = 1'b0; mem_err = 1'b0;
    forever begin
      @(negedge clk);
      if (auto_resp) begin
        mem_done = 1'b0; mem_err = 1'b0;
        if (mem_req) begin
          int ch;
          logic [31:0] b;
          ch = int'(mem_ch);
          bursts++;
          if (glog_n < 16) begin glog[glog_n] = ch; glog_n++; end
          if (m_pkt[ch] == 0) m_pkt[ch] = (m_cnt[ch] < PKT) ? m_cnt[ch] : PKT;
          b = (cap_bytes(m_burst[ch]) < m_pkt[ch]) ? cap_bytes(m_burst[ch]) : m_pkt[ch];
          check("R3 burst address", mem_addr, m_addr[ch]);
          check("R4 burst beats", {27'b0, mem_beats}, (b + 3) / 4);
          check("R1 direction", {31'b0, mem_write}, {31'b0, !m_tx[ch]});
          repeat ($urandom_range(0, 2)) @(negedge clk);
          if (err_arm && ch == err_ch) begin
            mem_err = 1'b1; err_arm = 1'b0;
          end else begin
            mem_done = 1'b1;
            m_addr[ch] += b; m_cnt[ch] -= b; m_pkt[ch] -= b;
          end
        end
      end
    end
  end

  task automatic summary;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; fifo_req = '0;
    for (int i = 0; i < 8; i++) begin m_addr[i] = 0; m_cnt[i] = 0; m_pkt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(12'h200, d); check("R8 reset status", d, 32'h0);
    rd(ra(0, 4), d); check("R1 reset ctrl", d, 32'h0);
    check("R8 reset irq", {31'b0, irq}, 32'h0);
    check("R4 reset mem_req", {31'b0, mem_req}, 32'h0);

    // R1 / R2 register layout
    wr(ra(3, 4), 32'h0000_07F6);
    rd(ra(3, 4), d); check("R1 ctrl readback, error bit cleared", d, 32'h0000_06F6);
    wr(ra(3, 8), 32'h1234_5677);
    rd(ra(3, 8), d); check("R2 address low bits", d, 32'h1234_5674);
    wr(ra(3, 12), 32'h0000_0123);
    rd(ra(3, 12), d); check("R1 count readback", d, 32'h0000_0123);

    // R12 zero count, R8 interrupt enable
    start_ch(1, 32'h40, 0, 1'b0, 2'd0, 1'b1, 1'b0, 4'd1);
    check("R8 irq after completion", {31'b0, irq}, 32'h1);
    rd(ra(1, 4), d); check("R12 zero count not active", {31'b0, d[0]}, 32'h0);
    rd(12'h200, d); check("R12 zero count status", d, 32'h02);
    check("R9 irq cleared by read", {31'b0, irq}, 32'h0);
    start_ch(7, 32'h40, 0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd7);
    rd(12'h200, d); check("R8 no status without enable", d, 32'h0);

    // R9 completion coinciding with status read
    start_ch(1, 32'h40, 0, 1'b0, 2'd0, 1'b1, 1'b0, 4'd1);
    auto_resp = 1'b0;
    start_ch(0, 32'h100, 4, 1'b0, 2'd0, 1'b1, 1'b0, 4'd0);
    fifo_req = 16'h0001;
    while (!mem_req) @(negedge clk);
    @(negedge clk);
    mem_done = 1'b1; reg_rd = 1'b1; reg_addr = 12'h200; #1 d = reg_rdata;
    @(negedge clk); mem_done = 1'b0; reg_rd = 1'b0;
    check("R9 read returns older bit", d, 32'h02);
    rd(12'h200, d); check("R9 same-cycle completion kept", d, 32'h01);
    rd(ra(0, 8), d); check("R3 address after single beat", d, 32'h104);
    auto_resp = 1'b1; fifo_req = '0;

    // R7 bus error
    err_arm = 1'b1; err_ch = 2;
    start_ch(2, 32'h400, 64, 1'b0, 2'd2, 1'b1, 1'b1, 4'd2);
    fifo_req = 16'h0004;
    repeat (15) @(negedge clk);
    fifo_req = '0;
    rd(ra(2, 4), d); check("R7 error flag set, channel stopped", d & 32'h101, 32'h100);
    rd(ra(2, 12), d); check("R7 count unchanged", d, 32'd64);
    rd(ra(2, 8), d); check("R7 address unchanged", d, 32'h400);
    rd(12'h200, d); check("R7 error interrupt", d, 32'h04);

    // R6 multi-packet waits for the FIFO request
    bursts = 0;
    start_ch(4, 32'h800, 100, 1'b1, 2'd3, 1'b1, 1'b1, 4'd3);
    repeat (10) @(negedge clk);
    check("R6 no burst before request", bursts, 0);
    fifo_req = 16'h0008; @(negedge clk); fifo_req = '0;
    repeat (30) @(negedge clk);
    rd(ra(4, 12), d); check("R6 one packet moved", d, 32'd36);
    rd(12'h200, d); check("R6 not finished after one packet", d, 32'h0);
    fifo_req = 16'h0008; @(negedge clk); fifo_req = '0;
    repeat (30) @(negedge clk);
    rd(ra(4, 12), d); check("R6 count drained", d, 32'd0);
    rd(ra(4, 8), d); check("R3 address advanced", d, 32'h800 + 100);
    rd(12'h200, d); check("R6 finished", d, 32'h10);

    // R10 abort a waiting channel
    start_ch(6, 32'hA00, 32, 1'b0, 2'd1, 1'b1, 1'b0, 4'd6);
    wr(ra(6, 4), 32'h0);
    rd(ra(6, 4), d); check("R10 abort clears active", {31'b0, d[0]}, 32'h0);
    bursts = 0;
    fifo_req = 16'hFFFF;
    repeat (12) @(negedge clk);
    fifo_req = '0;
    check("R10 no bursts after abort", bursts, 0);
    rd(12'h200, d); check("R10 no interrupt after abort", d, 32'h0);
    wr(ra(6, 8), 32'h0); wr(ra(6, 12), 32'h0);
    rd(ra(6, 12), d); check("R10 count cleared", d, 32'h0);

    // R11 fixed priority
    start_ch(5, 32'h1000, 64, 1'b0, 2'd1, 1'b1, 1'b0, 4'd5);
    start_ch(2, 32'h2000, 64, 1'b0, 2'd1, 1'b1, 1'b0, 4'd2);
    glog_n = 0;
    fifo_req = 16'h0024;
    repeat (80) @(negedge clk);
    fifo_req = '0;
    check("R11 first grant lowest", glog[0], 2);
    check("R11 lower channel keeps bus", glog[3], 2);
    check("R11 higher channel after", glog[4], 5);
    rd(12'h200, d); check("R5 both single packets done", d, 32'h24);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      logic [7:0]  mask, got;
      logic [31:0] sa[8], sc[8];
      logic        sm[8];
      mask = 8'($urandom_range(1, 255));
      for (int c = 0; c < 8; c++) begin
        if (mask[c]) begin
          sa[c] = $urandom & 32'h00FF_FFFF;
          sc[c] = $urandom_range(1, 200);
          sm[c] = 1'($urandom_range(0, 1));
          start_ch(c, sa[c], sc[c], sm[c], 2'($urandom_range(0, 3)), 1'b1,
                   1'($urandom_range(0, 1)), 4'(c + 8));
        end
      end
      got = '0;
      for (int k = 0; k < 4000 && got != mask; k++) begin
        fifo_req = 16'($urandom);
        rd(12'h200, d);
        got |= d[7:0];
      end
      fifo_req = '0;
      check("R8 random completions", {24'b0, got}, {24'b0, mask});
      for (int c = 0; c < 8; c++) begin
        if (mask[c]) begin
          rd(ra(c, 8), d);
          check(sm[c] ? "R6 random final address" : "R5 random final address",
                d, {sa[c][31:2], 2'b00} + moved(sc[c], sm[c]));
          rd(ra(c, 12), d);
          check("R3 random final count", d, sc[c] - moved(sc[c], sm[c]));
        end
      end
    end

    summary();
  end
endmodule